// File: doc/BRIEF.md
# Word-Serial AES Key Expander

This block turns an AES cipher key into its full round-key schedule. The key enters on a 32-bit bus, one word per clock, while a load strobe is high. A new-key pulse accompanies the first word. The words arrive highest-index first, so the final word presented is schedule word 0. The block counts the words held under the strobe, and that count alone selects the variant: four words give AES-128, six give AES-192 and eight give AES-256.

When the strobe falls, the expander writes one schedule word per clock into its internal word store. It computes each word from two stored words: the one just before it and the one a full key length back. A SubWord stage with four byte substitution lanes and a round-constant generator feed this step. A flag goes high once the last word is written. From then on, a cipher datapath can read any schedule word by index through a combinational read port.

Top module: `aes_key_expander`

## Requirements
- R1: Key words are presented highest index first. After a valid load, reading index j (j below the key length in words) returns the j-th word of the key, where word 0 is the key's most significant 32 bits (the last word presented).
- R2: The number of words presented while `key_load` is high selects the variant: 4, 6 or 8 words give schedules of 44, 52 or 60 words. Indices from the schedule length up to 63 read as zero.
- R3: Each word at index i ≥ Nk equals word i−Nk XOR a temporary value. The temporary value is one of the following:
  - When i mod Nk = 0, it is SubWord(RotWord(word i−1)) XOR the round constant placed in the most significant byte.
  - For the 8-word key with i mod 8 = 4, it is SubWord(word i−1).
  - Otherwise, it is word i−1.
  - RotWord moves the most significant byte to the least significant position.
- R4: The round constant starts at 01 for each new expansion and is doubled in GF(2^8) modulo 0x11B after each use: 01, 02, 04, 08, 10, 20, 40, 80, 1b, 36.
- R5: `sched_ready` rises exactly (schedule length − Nk + 1) clock edges after the first edge that samples `key_load` low following a valid load: 41, 47 or 53 edges. It then stays high until reset or a new key.
- R6: A clock edge with `key_load` and `key_new` both high clears `sched_ready`. The same edge makes every read return zero and restarts the word count, even during an expansion in progress.
- R7: If `key_load` falls after a count other than 4, 6 or 8 words, `sched_ready` stays low and every read returns zero.
- R8: `rd_word` follows `rd_idx` combinationally. It is zero whenever `sched_ready` is low or the index is at or beyond the schedule length.
- R9: Synchronous active-high reset clears `sched_ready` and makes every read return zero, also during an expansion.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| key_word | input | 32 | Key word bus, highest index first |
| key_new | input | 1 | Marks the first word of a new key |
| key_load | input | 1 | High while key words are presented |
| sched_ready | output | 1 | Full schedule available (registered) |
| rd_idx | input | 6 | Schedule word index to read |
| rd_word | output | 32 | Schedule word at `rd_idx`, zero when invalid |

## Verification
The ready flag is the only timed result. Its rise is due exactly 41, 47 or 53 edges after the first edge that samples the load strobe low. The bench counts edges from that point, samples at each falling edge, and requires the flag low one edge before the due count and high at it. The clear caused by a new-key pulse or by reset is due after a single edge, and the bench checks it at the next falling edge. Read data is combinational, so each read is sampled one time unit after the index changes, well clear of any clock edge.

// File: rtl/aes_ks_pkg.sv
package aes_ks_pkg;

  localparam int KS_WORD_W    = 32;
  localparam int KS_MAX_NK    = 8;
  localparam int KS_MAX_WORDS = 4 * (KS_MAX_NK + 7);
  localparam int KS_IDX_W     = $clog2(KS_MAX_WORDS);
  localparam int KS_CNT_W     = 4;
  localparam int KS_PH_W      = $clog2(KS_MAX_NK);

  typedef enum logic [1:0] {
    KS_IDLE   = 2'd0,
    KS_LOAD   = 2'd1,
    KS_EXPAND = 2'd2
  } ks_state_e;

  // GF(2^8) doubling modulo x^8+x^4+x^3+x+1
  function automatic logic [7:0] gf_dbl(input logic [7:0] a);
    gf_dbl = a[7] ? ((a << 1) ^ 8'h1b) : (a << 1);
  endfunction

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc;
    logic [7:0] sh;
    acc = 8'h00;
    sh  = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = gf_dbl(sh);
    end
    gf_mul = acc;
  endfunction

  // Forward S-box: inverse via x^254, then affine map
  function automatic logic [7:0] sbox_fwd(input logic [7:0] x);
    logic [7:0] sq;
    logic [7:0] inv;
    sq  = x;
    inv = 8'h01;
    for (int k = 1; k < 8; k++) begin
      sq  = gf_mul(sq, sq);
      inv = gf_mul(inv, sq);
    end
    sbox_fwd = inv
             ^ {inv[6:0], inv[7]}
             ^ {inv[5:0], inv[7:6]}
             ^ {inv[4:0], inv[7:5]}
             ^ {inv[3:0], inv[7:4]}
             ^ 8'h63;
  endfunction

endpackage

// File: rtl/aes_ks_subword.sv
module aes_ks_subword
  import aes_ks_pkg::*;
#(
  parameter int WORD_W = KS_WORD_W
) (
  input  logic [WORD_W-1:0] din,
  output logic [WORD_W-1:0] dout
);
  localparam int LANES = WORD_W / 8;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_comb dout[g*8 +: 8] = sbox_fwd(din[g*8 +: 8]);
  end

endmodule

// File: rtl/aes_ks_rcon.sv
module aes_ks_rcon
  import aes_ks_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       restart,
  input  logic       advance,
  output logic [7:0] rcon
);
  logic [7:0] rcon_q;

  always_ff @(posedge clk) begin
    if (rst || restart) rcon_q <= 8'h01;
    else if (advance)   rcon_q <= gf_dbl(rcon_q);
  end

  assign rcon = rcon_q;

endmodule

// File: rtl/aes_ks_store.sv
module aes_ks_store
  import aes_ks_pkg::*;
#(
  parameter int WORD_W    = KS_WORD_W,
  parameter int MAX_NK    = KS_MAX_NK,
  parameter int MAX_WORDS = KS_MAX_WORDS,
  parameter int IDX_W     = KS_IDX_W
) (
  input  logic              clk,
  input  logic              shift_en,
  input  logic [WORD_W-1:0] shift_word,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  prev_idx,
  output logic [WORD_W-1:0] prev_word,
  input  logic [IDX_W-1:0]  back_idx,
  output logic [WORD_W-1:0] back_word,
  input  logic [IDX_W-1:0]  ext_idx,
  input  logic [IDX_W-1:0]  valid_len,
  output logic [WORD_W-1:0] ext_word
);
  logic [WORD_W-1:0] mem [MAX_WORDS];

  // Loading shifts toward higher indices, so the last word lands at 0
  always_ff @(posedge clk) begin
    if (shift_en) begin
      mem[0] <= shift_word;
      for (int k = 1; k < MAX_NK; k++) mem[k] <= mem[k-1];
    end else if (wr_en) begin
      mem[wr_idx] <= wr_data;
    end
  end

  assign prev_word = mem[prev_idx];
  assign back_word = mem[back_idx];
  assign ext_word  = (ext_idx < valid_len) ? mem[ext_idx] : '0;

endmodule

// File: rtl/aes_key_expander.sv
module aes_key_expander
  import aes_ks_pkg::*;
#(
  parameter int WORD_W    = KS_WORD_W,
  parameter int MAX_NK    = KS_MAX_NK,
  parameter int MAX_WORDS = KS_MAX_WORDS,
  parameter int IDX_W     = KS_IDX_W,
  parameter int CNT_W     = KS_CNT_W,
  parameter int PH_W      = KS_PH_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] key_word,
  input  logic              key_new,
  input  logic              key_load,
  output logic              sched_ready,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [WORD_W-1:0] rd_word
);
  localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(MAX_NK + 1);

  ks_state_e         state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  nk_q;
  logic [IDX_W-1:0]  idx_q;
  logic [PH_W-1:0]   ph_q;
  logic [IDX_W-1:0]  len_q;
  logic              ready_q;

  logic              restart_key;
  logic              cnt_valid;
  logic [IDX_W-1:0]  total_w;
  logic              last_word;
  logic              shift_en;
  logic              wr_en;
  logic              rcon_restart;
  logic              rcon_adv;
  logic [7:0]        rcon;
  logic [WORD_W-1:0] prev_word;
  logic [WORD_W-1:0] back_word;
  logic [WORD_W-1:0] sub_in;
  logic [WORD_W-1:0] sub_out;
  logic [WORD_W-1:0] temp_w;
  logic [WORD_W-1:0] new_word;

  assign restart_key = key_load && key_new;
  assign cnt_valid   = (cnt_q == CNT_W'(4)) || (cnt_q == CNT_W'(6)) ||
                       (cnt_q == CNT_W'(8));
  assign total_w     = IDX_W'((IDX_W'(nk_q) + IDX_W'(7)) << 2);
  assign last_word   = (idx_q == total_w - IDX_W'(1));

  assign shift_en     = key_load && (key_new || state_q == KS_LOAD);
  assign wr_en        = !restart_key && (state_q == KS_EXPAND);
  assign rcon_restart = !restart_key && (state_q == KS_LOAD) && !key_load && cnt_valid;
  assign rcon_adv     = wr_en && (ph_q == '0);

  // Expansion step
  always_comb begin
    sub_in = (ph_q == '0) ? {prev_word[WORD_W-9:0], prev_word[WORD_W-1 -: 8]}
                          : prev_word;
    if (ph_q == '0)
      temp_w = sub_out ^ {rcon, {(WORD_W-8){1'b0}}};
    else if (nk_q == CNT_W'(8) && ph_q == PH_W'(4))
      temp_w = sub_out;
    else
      temp_w = prev_word;
    new_word = back_word ^ temp_w;
  end

  aes_ks_subword #(.WORD_W(WORD_W)) u_sub (
    .din  (sub_in),
    .dout (sub_out)
  );

  aes_ks_rcon u_rcon (
    .clk     (clk),
    .rst     (rst),
    .restart (rcon_restart),
    .advance (rcon_adv),
    .rcon    (rcon)
  );

  aes_ks_store #(
    .WORD_W    (WORD_W),
    .MAX_NK    (MAX_NK),
    .MAX_WORDS (MAX_WORDS),
    .IDX_W     (IDX_W)
  ) u_store (
    .clk        (clk),
    .shift_en   (shift_en),
    .shift_word (key_word),
    .wr_en      (wr_en),
    .wr_idx     (idx_q),
    .wr_data    (new_word),
    .prev_idx   (idx_q - IDX_W'(1)),
    .prev_word  (prev_word),
    .back_idx   (idx_q - IDX_W'(nk_q)),
    .back_word  (back_word),
    .ext_idx    (rd_idx),
    .valid_len  (len_q),
    .ext_word   (rd_word)
  );

  // Control
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= KS_IDLE;
      cnt_q   <= '0;
      nk_q    <= CNT_W'(4);
      idx_q   <= '0;
      ph_q    <= '0;
      len_q   <= '0;
      ready_q <= 1'b0;
    end else if (restart_key) begin
      state_q <= KS_LOAD;
      cnt_q   <= CNT_W'(1);
      len_q   <= '0;
      ready_q <= 1'b0;
    end else begin
      case (state_q)
        KS_LOAD: begin
          if (key_load) begin
            cnt_q <= (cnt_q == CNT_SAT) ? CNT_SAT : cnt_q + CNT_W'(1);
          end else if (cnt_valid) begin
            nk_q    <= cnt_q;
            idx_q   <= IDX_W'(cnt_q);
            ph_q    <= '0;
            state_q <= KS_EXPAND;
          end else begin
            state_q <= KS_IDLE;
          end
        end
        KS_EXPAND: begin
          if (last_word) begin
            state_q <= KS_IDLE;
            ready_q <= 1'b1;
            len_q   <= total_w;
          end else begin
            idx_q <= idx_q + IDX_W'(1);
            ph_q  <= (ph_q == PH_W'(nk_q - CNT_W'(1))) ? '0 : ph_q + PH_W'(1);
          end
        end
        default: state_q <= KS_IDLE;
      endcase
    end
  end

  assign sched_ready = ready_q;

endmodule

// File: rtl/aes_ks_checker.sv
module aes_ks_checker
  import aes_ks_pkg::*;
#(
  parameter int WORD_W    = KS_WORD_W,
  parameter int MAX_WORDS = KS_MAX_WORDS,
  parameter int IDX_W     = KS_IDX_W
) (
  input logic              clk,
  input logic              rst,
  input logic              key_new,
  input logic              key_load,
  input logic              sched_ready,
  input logic [IDX_W-1:0]  rd_idx,
  input logic [WORD_W-1:0] rd_word
);

  a_r9_reset_clears: assert property (@(posedge clk) rst |=> !sched_ready);

  a_r6_new_key_clears: assert property (@(posedge clk) disable iff (rst)
    (key_load && key_new) |=> !sched_ready);

  a_r8_zero_when_not_ready: assert property (@(posedge clk) disable iff (rst)
    !sched_ready |-> (rd_word == '0));

  a_r8_zero_beyond_store: assert property (@(posedge clk) disable iff (rst)
    (rd_idx >= IDX_W'(MAX_WORDS)) |-> (rd_word == '0));

  a_r5_ready_holds: assert property (@(posedge clk) disable iff (rst)
    (sched_ready && !(key_load && key_new)) |=> sched_ready);

  a_r5_rise_not_on_new_key: assert property (@(posedge clk) disable iff (rst)
    $rose(sched_ready) |-> !$past(key_load && key_new));

endmodule

bind aes_key_expander aes_ks_checker #(
  .WORD_W    (WORD_W),
  .MAX_WORDS (MAX_WORDS),
  .IDX_W     (IDX_W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .key_new     (key_new),
  .key_load    (key_load),
  .sched_ready (sched_ready),
  .rd_idx      (rd_idx),
  .rd_word     (rd_word)
);

// File: tb/aes_key_expander_tb.sv
module aes_key_expander_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] key_word = '0;
  logic        key_new = 1'b0;
  logic        key_load = 1'b0;
  logic        sched_ready;
  logic [5:0]  rd_idx = '0;
  logic [31:0] rd_word;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  aes_key_expander u_dut (
    .clk         (clk),
    .rst         (rst),
    .key_word    (key_word),
    .key_new     (key_new),
    .key_load    (key_load),
    .sched_ready (sched_ready),
    .rd_idx      (rd_idx),
    .rd_word     (rd_word)
  );

  // Keys, word 0 in the top 32 bits
  localparam logic [255:0] KEYS [5] = '{
    256'h2b7e1516_28aed2a6_abf71588_09cf4f3c_00000000_00000000_00000000_00000000,
    256'h8e73b0f7_da0e6452_c810f32b_809079e5_62f8ead2_522c6b7b_00000000_00000000,
    256'h603deb10_15ca71be_2b73aef0_857d7781_1f352c07_3b6108d7_2d9810a3_0914dff4,
    256'h00010203_04050607_08090a0b_0c0d0e0f_00000000_00000000_00000000_00000000,
    256'h00010203_04050607_08090a0b_0c0d0e0f_10111213_14151617_18191a1b_1c1d1e1f
  };
  localparam int NKS [5] = '{4, 6, 8, 4, 8};

  // {key id, index, expected word}
  localparam int NV = 32;
  localparam logic [40:0] VEC [NV] = '{
    {3'd0, 6'd0,  32'h2b7e1516}, {3'd0, 6'd3,  32'h09cf4f3c},
    {3'd0, 6'd4,  32'ha0fafe17}, {3'd0, 6'd5,  32'h88542cb1},
    {3'd0, 6'd6,  32'h23a33939}, {3'd0, 6'd7,  32'h2a6c7605},
    {3'd0, 6'd8,  32'hf2c295f2}, {3'd0, 6'd11, 32'h7359f67f},
    {3'd0, 6'd40, 32'hd014f9a8}, {3'd0, 6'd43, 32'hb6630ca6},
    {3'd1, 6'd0,  32'h8e73b0f7}, {3'd1, 6'd5,  32'h522c6b7b},
    {3'd1, 6'd6,  32'hfe0c91f7}, {3'd1, 6'd7,  32'h2402f5a5},
    {3'd1, 6'd8,  32'hec12068e}, {3'd1, 6'd11, 32'h5c56fec2},
    {3'd1, 6'd48, 32'he98ba06f}, {3'd1, 6'd51, 32'h01002202},
    {3'd2, 6'd0,  32'h603deb10}, {3'd2, 6'd7,  32'h0914dff4},
    {3'd2, 6'd8,  32'h9ba35411}, {3'd2, 6'd11, 32'h2067fcde},
    {3'd2, 6'd12, 32'ha8b09c1a}, {3'd2, 6'd13, 32'h93d194cd},
    {3'd2, 6'd56, 32'hfe4890d1}, {3'd2, 6'd59, 32'h706c631e},
    {3'd3, 6'd0,  32'h00010203}, {3'd3, 6'd3,  32'h0c0d0e0f},
    {3'd3, 6'd40, 32'h13111d7f}, {3'd3, 6'd43, 32'h4d2b30c5},
    {3'd4, 6'd56, 32'h24fc79cc}, {3'd4, 6'd59, 32'h6d68de36}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] kw(input int k, input int j);
    logic [255:0] kk;
    kk = KEYS[k];
    kw = kk[255 - 32*j -: 32];
  endfunction

  // Present nw words of key k, highest index first; load low afterwards
  task automatic load_words(input int k, input int nw);
    @(negedge clk);
    key_load = 1'b1;
    key_new  = 1'b1;
    key_word = kw(k, nw - 1);
    for (int j = nw - 2; j >= 0; j--) begin
      @(negedge clk);
      key_new  = 1'b0;
      key_word = kw(k, j);
    end
    @(negedge clk);
    key_new  = 1'b0;
    key_load = 1'b0;
    key_word = '0;
  endtask

  // Count edges from the first edge sampling load low until ready (R5)
  task automatic load_and_time(input int k);
    int n;
    int due;
    logic seen_low;
    load_words(k, NKS[k]);
    due = 4 * (NKS[k] + 7) - NKS[k] + 1;
    n = 0;
    seen_low = 1'b0;
    while (!sched_ready && n < 200) begin
      @(posedge clk);
      @(negedge clk);
      n++;
      if (n == due - 1) seen_low = !sched_ready;
    end
    check("R5 ready low one edge early", {31'd0, seen_low}, 32'd1);
    check("R5 ready edge count", n, due);
  endtask

  task automatic read_check(input string req, input logic [5:0] idx, input logic [31:0] exp);
    rd_idx = idx;
    #1;
    check(req, rd_word, exp);
  endtask

  initial begin
    int cur;
    // R9: reset state
    repeat (4) @(negedge clk);
    check("R9 ready after reset", {31'd0, sched_ready}, 32'd0);
    read_check("R9 read after reset", 6'd0, 32'h0);
    rst = 1'b0;

    // Vector table: R1 load order, R2 lengths, R3 rule, R4 round constants (words 40..43)
    cur = -1;
    for (int v = 0; v < NV; v++) begin
      logic [40:0] e;
      e = VEC[v];
      if (int'(e[40:38]) != cur) begin
        cur = int'(e[40:38]);
        load_and_time(cur);
      end
      read_check("R1/R3 schedule word", e[37:32], e[31:0]);
    end

    // R8: out-of-range reads on a 60-word schedule
    read_check("R8 index 60", 6'd60, 32'h0);
    read_check("R8 index 63", 6'd63, 32'h0);
    read_check("R8 index 59", 6'd59, 32'h6d68de36);

    // R2: 44-word schedule ends at index 43
    load_and_time(3);
    read_check("R2 index 43", 6'd43, 32'h4d2b30c5);
    read_check("R2 index 44", 6'd44, 32'h0);

    // R6: new-key pulse clears ready and reads on the next edge
    @(negedge clk);
    key_load = 1'b1; key_new = 1'b1; key_word = 32'h11111111;
    @(negedge clk);
    key_load = 1'b0; key_new = 1'b0;
    check("R6 ready cleared", {31'd0, sched_ready}, 32'd0);
    read_check("R6 read cleared", 6'd0, 32'h0);

    // R7: five words is not a valid length
    load_words(0, 5);
    repeat (80) @(negedge clk);
    check("R7 ready stays low", {31'd0, sched_ready}, 32'd0);
    read_check("R7 read zero", 6'd4, 32'h0);

    // R6: new key during an expansion restarts it
    load_words(0, 4);
    repeat (5) @(negedge clk);
    load_and_time(3);
    read_check("R6 restarted schedule", 6'd40, 32'h13111d7f);

    // R9: reset during an expansion
    load_words(2, 8);
    repeat (10) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    repeat (70) @(negedge clk);
    check("R9 no ready after mid reset", {31'd0, sched_ready}, 32'd0);
    read_check("R9 read after mid reset", 6'd8, 32'h0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule